// File: doc/BRIEF.md
# Shared-ALU Register Datapath

This block is the register-transfer core of a small processor. Seven general registers, numbered 1 to 7, share one arithmetic and logic unit. Two read multiplexers each pick a register or the external input. Their outputs form operand bus A and operand bus B. The unit combines the two operands, and the result goes straight out on the output data port. A destination decoder can then capture that result into one register at the next rising edge. A four-bit status register keeps carry, sign, zero and overflow from the most recent recognised operation.

A 14-bit control word is applied on every clock, and the datapath has no sequencing of its own. An outside controller supplies one control word per cycle. Each control word describes one complete register transfer, such as "R1 gets R2 minus R3" or "send R2 to the output".

Top module: `shared_alu_datapath`

## Requirements
- R1: The control word is split, from bit 13 down to bit 0, into the A source select [13:11], the B source select [10:8], the destination select [7:5] and the operation code [4:0].
- R2: Each source select works on its own. Code 000 puts the external input on the bus, and code k from 1 to 7 puts register k on the bus.
- R3: Destination code 000 leaves all seven registers unchanged. The result still appears on the output data port.
- R4: Destination code k from 1 to 7 loads the result into register k at the rising edge, and only into register k.
- R5: The output data port shows the result of the control word currently applied, in the same cycle, with no register in the path.
- R6: Arithmetic codes give results modulo 256. 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A−B, and 00110 gives A−1.
- R7: Logic and shift codes work as follows. 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A. 10000 shifts A right by one and brings in a 0. 11000 shifts A left by one and brings in a 0.
- R8: The status port is laid out as bit 3 carry, bit 2 sign, bit 1 zero and bit 0 overflow. After each recognised operation these bits update at the rising edge. Sign takes result bit 7, and zero is set when the result is 0.
- R9: For increment, add, subtract and decrement, carry is the carry out of bit 7. Subtract is done as A + NOT B + 1, and decrement as A + 0xFF. Overflow is the XOR of the carry into bit 7 and the carry out of bit 7.
- R10: Pass, logic and shift operations set overflow to 0 and carry to 0. The exception is left shift, which puts the old A bit 7 into carry.
- R11: An operation code not listed in R6 or R7 gives A as the result and leaves the status bits unchanged.
- R12: A synchronous active-high reset clears all registers and status bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 14 | Control word for this cycle |
| ext_in | input | 8 | External input data, selectable onto either bus |
| out_data | output | 8 | Result of the current operation |
| status | output | 4 | Carry, sign, zero and overflow |

## Verification
The result on `out_data` depends only on inputs and register state, so the bench checks it one nanosecond after it drives a new control word, within the same cycle. The register write and the status update come one edge later. The bench checks the status just after that edge. It checks a register write when a later control word reads the register back onto a bus. A behavioural model moves forward one step per clock, in the same order, so each expected value is compared in the cycle it becomes due.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [4:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  // True for every code that has a defined operation.
  function automatic logic op_listed(input logic [4:0] op);
    case (op)
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC,
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: op_listed = 1'b1;
      default: op_listed = 1'b0;
    endcase
  endfunction

  // True for the codes that go through the adder.
  function automatic logic op_arith(input logic [4:0] op);
    case (op)
      OP_INC, OP_ADD, OP_SUB, OP_DEC: op_arith = 1'b1;
      default: op_arith = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sdp_read_mux.sv
module sdp_read_mux #(
  parameter int DW   = 8,
  parameter int SELW = 3,
  parameter int NREG = 7
) (
  input  logic [SELW-1:0]          sel,
  input  logic [DW-1:0]            ext,
  input  logic [NREG:1][DW-1:0]    regs,
  output logic [DW-1:0]            bus
);
  // Code 0 picks the external input, and code k picks register k.
  always_comb begin
    bus = ext;
    for (int k = 1; k <= NREG; k++) begin
      if (sel == SELW'(k)) bus = regs[k];
    end
  end
endmodule

// File: rtl/sdp_alu.sv
module sdp_alu
  import sdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [4:0]    op,
  output logic [DW-1:0] res,
  output flags_t        nxt_flags,
  output logic          listed,
  output logic          arith
);
  // Returns {carry out of msb, carry into msb, sum}.
  function automatic logic [DW+1:0] add_core(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y,
                                             input logic          cin);
    logic [DW-1:0] lo;
    logic [1:0]    hi;
    lo = {1'b0, x[DW-2:0]} + {1'b0, y[DW-2:0]} + {{(DW-1){1'b0}}, cin};
    hi = {1'b0, x[DW-1]} + {1'b0, y[DW-1]} + {1'b0, lo[DW-1]};
    return {hi[1], lo[DW-1], hi[0], lo[DW-2:0]};
  endfunction

  logic [DW-1:0] add_y;
  logic          add_cin;
  logic [DW+1:0] add_out;
  logic [DW-1:0] lsr_res;
  logic          c_end;
  logic          c_msb;

  assign listed = op_listed(op);
  assign arith  = op_arith(op);

  // One adder: the operation only changes the second operand and carry in.
  always_comb begin
    add_y   = '0;
    add_cin = 1'b0;
    case (op)
      OP_INC: add_cin = 1'b1;
      OP_ADD: add_y   = b;
      OP_SUB: begin add_y = ~b; add_cin = 1'b1; end
      OP_DEC: add_y   = '1;
      default: ;
    endcase
  end

  assign add_out = add_core(a, add_y, add_cin);
  assign c_end   = add_out[DW+1];
  assign c_msb   = add_out[DW];

  always_comb begin
    case (op)
      OP_AND:  lsr_res = a & b;
      OP_OR:   lsr_res = a | b;
      OP_XOR:  lsr_res = a ^ b;
      OP_NOT:  lsr_res = ~a;
      OP_SHR:  lsr_res = {1'b0, a[DW-1:1]};
      OP_SHL:  lsr_res = {a[DW-2:0], 1'b0};
      default: lsr_res = a;
    endcase
  end

  assign res = arith ? add_out[DW-1:0] : lsr_res;

  always_comb begin
    nxt_flags.s = res[DW-1];
    nxt_flags.z = (res == '0);
    if (arith) begin
      nxt_flags.c = c_end;
      nxt_flags.v = c_end ^ c_msb;
    end else begin
      nxt_flags.c = (op == OP_SHL) ? a[DW-1] : 1'b0;
      nxt_flags.v = 1'b0;
    end
  end
endmodule

// File: rtl/sdp_regbank.sv
module sdp_regbank #(
  parameter int DW   = 8,
  parameter int SELW = 3,
  parameter int NREG = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SELW-1:0]       wsel,
  input  logic [DW-1:0]         wdata,
  output logic [NREG:1][DW-1:0] regs
);
  logic [NREG:1] we;

  // One-hot destination decoder. Code 0 enables nothing.
  for (genvar k = 1; k <= NREG; k++) begin : g_dec
    assign we[k] = (wsel == SELW'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int k = 1; k <= NREG; k++) begin
        if (we[k]) regs[k] <= wdata;
      end
    end
  end

  p_dec_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));

  p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wsel == '0) |=> $stable(regs));

  for (genvar k = 1; k <= NREG; k++) begin : g_chk
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
      we[k] |=> (regs[k] == $past(wdata)));
  end
endmodule

// File: rtl/shared_alu_datapath.sv
module shared_alu_datapath
  import sdp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SELW = 3,
  parameter int OPW  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3*SELW+OPW-1:0]   ctrl_word,
  input  logic [DW-1:0]           ext_in,
  output logic [DW-1:0]           out_data,
  output logic [3:0]              status
);
  localparam int NREG  = (1 << SELW) - 1;
  localparam int CW    = 3 * SELW + OPW;
  localparam int A_LSB = CW - SELW;
  localparam int B_LSB = A_LSB - SELW;
  localparam int D_LSB = B_LSB - SELW;

  logic [SELW-1:0]       sel_a, sel_b, sel_d;
  logic [OPW-1:0]        op;
  logic [NREG:1][DW-1:0] regs;
  logic [DW-1:0]         bus_a, bus_b, alu_res;
  flags_t                nxt_flags, flags_q;
  logic                  listed, arith;

  assign sel_a = ctrl_word[A_LSB +: SELW];
  assign sel_b = ctrl_word[B_LSB +: SELW];
  assign sel_d = ctrl_word[D_LSB +: SELW];
  assign op    = ctrl_word[OPW-1:0];

  sdp_read_mux #(.DW(DW), .SELW(SELW), .NREG(NREG)) u_mux_a (
    .sel(sel_a), .ext(ext_in), .regs(regs), .bus(bus_a));

  sdp_read_mux #(.DW(DW), .SELW(SELW), .NREG(NREG)) u_mux_b (
    .sel(sel_b), .ext(ext_in), .regs(regs), .bus(bus_b));

  sdp_alu #(.DW(DW)) u_alu (
    .a(bus_a), .b(bus_b), .op(op), .res(alu_res),
    .nxt_flags(nxt_flags), .listed(listed), .arith(arith));

  sdp_regbank #(.DW(DW), .SELW(SELW), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wsel(sel_d), .wdata(alu_res), .regs(regs));

  always_ff @(posedge clk) begin
    if (rst)         flags_q <= '0;
    else if (listed) flags_q <= nxt_flags;
  end

  assign out_data = alu_res;
  assign status   = flags_q;

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !listed |=> $stable(flags_q));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    listed |=> (flags_q.z == ($past(out_data) == '0)));

  p_sign_flag_r8: assert property (@(posedge clk) disable iff (rst)
    listed |=> (flags_q.s == $past(out_data[DW-1])));

  p_shl_carry_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHL) |=> (flags_q.c == $past(bus_a[DW-1])));

  p_no_ovf_r10: assert property (@(posedge clk) disable iff (rst)
    (listed && !arith) |=> !flags_q.v);

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (status == 4'b0000));
endmodule

// File: tb/shared_alu_datapath_tb.sv
module shared_alu_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  out_data;
  logic [3:0]  status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int mreg [8];
  int mflags = 0;

  always #4 clk = ~clk;

  shared_alu_datapath u_dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
    .out_data(out_data), .status(status));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Behavioural model of one operation, written from the requirements.
  task automatic model_alu(input int op, input int a, input int b,
                           output int r, output int c, output int v,
                           output bit known);
    int t;
    known = 1; c = 0; v = 0;
    case (op)
      0:  r = a;
      1:  begin r = a + 1; c = (a == 255); t = sgn(a) + 1; v = (t > 127); end
      2:  begin r = a + b; c = (a + b > 255); t = sgn(a) + sgn(b);
                v = (t > 127 || t < -128); end
      5:  begin r = a - b; c = (a >= b); t = sgn(a) - sgn(b);
                v = (t > 127 || t < -128); end
      6:  begin r = a - 1; c = (a != 0); t = sgn(a) - 1; v = (t < -128); end
      8:  r = a & b;
      10: r = a | b;
      12: r = a ^ b;
      14: r = 255 - a;
      16: r = a / 2;
      24: begin r = a * 2; c = a / 128; end
      default: begin r = a; known = 0; end
    endcase
    r = r & 255;
  endtask

  // Apply one control word and check both the result and the next status.
  task automatic step(input logic [13:0] cw, input int din, input string tag);
    int sa, sb, sd, op, a, b, r, c, v, expf;
    bit known;
    string otag, ftag;
    @(negedge clk);
    ctrl_word = cw;
    ext_in = din[7:0];
    sa = int'(cw[13:11]); sb = int'(cw[10:8]); sd = int'(cw[7:5]); op = int'(cw[4:0]);
    a = (sa == 0) ? din : mreg[sa];
    b = (sb == 0) ? din : mreg[sb];
    model_alu(op, a, b, r, c, v, known);
    if (tag != "") otag = tag;
    else if (!known) otag = "R11";
    else if (op == 1 || op == 2 || op == 5 || op == 6 || op == 0) otag = "R6";
    else otag = "R7";
    #1;
    check(otag, int'(out_data), r);
    if (known) begin
      expf = (c << 3) | ((r / 128) << 2) | ((r == 0) << 1) | v;
      mflags = expf;
      ftag = (op == 1 || op == 2 || op == 5 || op == 6) ? "R9" : "R10";
    end else begin
      ftag = "R11";
    end
    if (sd != 0) mreg[sd] = r;
    @(posedge clk);
    #1;
    check(ftag, int'(status), mflags);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) mreg[k] = 0;
    mflags = 0;
    #1;
    check("R12", int'(status), 0);
    for (int k = 1; k < 8; k++) step({3'(k), 3'd0, 3'd0, 5'b00000}, 0, "R12");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mreg[k] = 0;
    do_reset();

    // Load every register from the input (R4).
    for (int k = 1; k < 8; k++) step({3'd0, 3'd0, 3'(k), 5'b00000}, 16 * k + 3, "R4");
    // Read each register through bus B; A takes the input 0 (R2).
    for (int k = 1; k < 8; k++) step({3'd0, 3'(k), 3'd0, 5'b00010}, 0, "R2");

    // Field layout taken literally (R1): R1 <- R2 - R3, then R4 <- R4 | R5.
    step(14'b010_011_001_00101, 0, "R1");
    step(14'b100_101_100_01010, 0, "R1");
    step(14'b001_000_000_00000, 0, "R4");   // read back R1
    step(14'b101_101_101_01100, 0, "R7");   // R5 <- 0
    step(14'b000_000_000_00000, 8'hA5, "R5"); // input to output, same cycle
    step(14'b010_000_000_00000, 0, "R3");   // output R2, no write
    step(14'b010_000_000_00000, 0, "R3");

    // Overflow and carry corners (R9).
    step({3'd0, 3'd0, 3'd1, 5'b00000}, 8'h7F, "R4");
    step({3'd1, 3'd0, 3'd1, 5'b00001}, 0, "R6");   // 7F+1
    step({3'd0, 3'd0, 3'd2, 5'b00000}, 8'h80, "R4");
    step({3'd2, 3'd0, 3'd3, 5'b00110}, 0, "R6");   // 80-1
    step({3'd2, 3'd2, 3'd4, 5'b00010}, 0, "R6");   // 80+80
    step({3'd2, 3'd0, 3'd0, 5'b00101}, 1, "R6");   // 80-1 via SUB
    step({3'd0, 3'd0, 3'd0, 5'b00001}, 8'hFF, "R6");
    step({3'd0, 3'd0, 3'd0, 5'b00110}, 8'h00, "R6");
    // Shifts (R10).
    step({3'd0, 3'd0, 3'd6, 5'b11000}, 8'h81, "R7");
    step({3'd6, 3'd0, 3'd6, 5'b10000}, 0, "R7");
    step({3'd0, 3'd0, 3'd0, 5'b01110}, 8'h0F, "R7");
    // Unlisted codes after a flag-setting op (R11).
    step({3'd0, 3'd0, 3'd0, 5'b00010}, 8'hC0, "R6");
    step({3'd0, 3'd0, 3'd7, 5'b00011}, 8'h00, "R11");
    step({3'd7, 3'd0, 3'd0, 5'b11111}, 8'h00, "R11");

    // Random control words.
    for (int i = 0; i < 2000; i++) step(14'($urandom), int'($urandom & 255), "");

    do_reset();
    step({3'd0, 3'd0, 3'd0, 5'b00000}, 8'h3C, "R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule